// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands over several clock cycles with one W-bit adder. The multiplicand sits in a register that never shifts. A single 2W-bit accumulator does two jobs. Its lower half first holds the multiplier, and product bits fill that half as the accumulator moves right one place per cycle. Each cycle looks at the accumulator's least significant bit. When that bit is 1, the multiplicand is added into the upper half. The whole register then shifts right by one place, and the adder's carry-out becomes the new most significant bit.

A request is a single-cycle `start_i` with both operands and a mode bit. The result appears as two W-bit halves, an upper word and a lower word, and `done_o` pulses once to mark it valid. In signed mode the block works on operand magnitudes and negates the 2W-bit result when the operand signs differ.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst` is high and after it is released, `busy_o` and `done_o` are 0 and `res_hi_o`/`res_lo_o` are 0 until the first result completes.
- R2: With `signed_i`=0 at the accepted start, the concatenation {`res_hi_o`,`res_lo_o`} equals the unsigned product of `op_a_i` and `op_b_i`, with the upper W bits in `res_hi_o`.
- R3: No carry is lost: all-ones times all-ones in unsigned mode gives (2^W-1)^2.
- R4: A start accepted at clock edge k raises `busy_o` from edge k until edge k+W. `done_o` is high for the cycle after edge k+W, which is W+1 clock edges of latency including the load edge.
- R5: `done_o` is high for exactly one cycle per accepted start.
- R6: A `start_i` raised while `busy_o` is 1 is ignored. The running operation keeps its operands and its timing.
- R7: With `signed_i`=1, both operands are read as two's complement and {`res_hi_o`,`res_lo_o`} is the 2W-bit two's-complement product.
- R8: In signed mode the most negative operand (bit W-1 set, all other bits 0) is multiplied correctly, including most negative times most negative.
- R9: The result halves hold their value between completions.
- R10: A start raised in the cycle where `done_o` is 1 is accepted, because `busy_o` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken only when not busy |
| signed_i | input | 1 | 1 selects two's-complement operands |
| op_a_i | input | W | Multiplicand |
| op_b_i | input | W | Multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| res_hi_o | output | W | Upper half of the product |
| res_lo_o | output | W | Lower half of the product |

## Verification
The completion pulse of one product and the acceptance of the next request fall in the same cycle. The bench provokes this on nearly every operation: it issues the next request in the very cycle it observes `done_o`. It then judges that the finished result is correct, that the new request starts its full W+1 cycle latency, and that the result of the new request is correct. A second collision, a request made during the iterations, is judged by checking that the pending result and its timing stay unchanged.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic sgn_mode;
        logic negate;
    } op_flags_t;

    function automatic logic signs_differ(input logic sgn_mode, input logic a_msb,
                                          input logic b_msb);
        return sgn_mode & (a_msb ^ b_msb);
    endfunction

endpackage

// File: rtl/sam_prep.sv
module sam_prep #(
    parameter int W = 8
) (
    input  logic                 sgn_mode,
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    output logic [W-1:0]         mag_a,
    output logic [W-1:0]         mag_b,
    output smul_pkg::op_flags_t  flags
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg = sgn_mode & op_a[W-1];
        b_neg = sgn_mode & op_b[W-1];
        // the most negative value maps onto itself, read as an unsigned magnitude
        mag_a = a_neg ? (~op_a + 1'b1) : op_a;
        mag_b = b_neg ? (~op_b + 1'b1) : op_b;
        flags.sgn_mode = sgn_mode;
        flags.negate   = smul_pkg::signs_differ(sgn_mode, op_a[W-1], op_b[W-1]);
    end
endmodule

// File: rtl/sam_step.sv
module sam_step #(
    parameter int W = 8
) (
    input  logic [W-1:0]   mcand,
    input  logic [2*W-1:0] acc,
    output logic [2*W-1:0] acc_next
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : '0);
        // carry lands in the MSB while everything moves right one place
        acc_next = {sum, acc[W-1:1]};
    end
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    import smul_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    mul_state_e     state;
    logic [CW-1:0]  iter;

    always_comb begin
        busy = (state == ST_RUN);
        load = start && (state == ST_IDLE);
        step = (state == ST_RUN);
        last = step && (iter == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                state <= ST_RUN;
                iter  <= '0;
            end else if (step) begin
                iter <= iter + 1'b1;
                if (last) state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/sam_fix.sv
module sam_fix #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] acc,
    input  logic           negate,
    output logic [2*W-1:0] result
);
    always_comb begin
        result = negate ? (~acc + 1'b1) : acc;
    end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] res_hi_o,
    output logic [W-1:0] res_lo_o
);
    import smul_pkg::*;

    localparam int PW = 2 * W;

    logic [W-1:0]  mag_a, mag_b;
    op_flags_t     in_flags, run_flags;
    logic [W-1:0]  mcand_q;
    logic [PW-1:0] acc_q, acc_nx, fixed;
    logic          load, step, last;

    sam_prep #(.W(W)) u_prep (
        .sgn_mode (signed_i),
        .op_a     (op_a_i),
        .op_b     (op_b_i),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .flags    (in_flags)
    );

    sam_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy_o),
        .done  (done_o)
    );

    sam_step #(.W(W)) u_step (
        .mcand    (mcand_q),
        .acc      (acc_q),
        .acc_next (acc_nx)
    );

    sam_fix #(.W(W)) u_fix (
        .acc    (acc_nx),
        .negate (run_flags.negate),
        .result (fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q   <= '0;
            acc_q     <= '0;
            run_flags <= '0;
            res_hi_o  <= '0;
            res_lo_o  <= '0;
        end else begin
            if (load) begin
                mcand_q   <= mag_a;
                acc_q     <= {{W{1'b0}}, mag_b};
                run_flags <= in_flags;
            end else if (step) begin
                acc_q <= acc_nx;
            end
            if (last) begin
                res_hi_o <= fixed[PW-1:W];
                res_lo_o <= fixed[W-1:0];
            end
        end
    end
endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         signed_i,
    input logic [W-1:0] op_a_i,
    input logic [W-1:0] op_b_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] res_hi_o,
    input logic [W-1:0] res_lo_o
);
    localparam int CW = $clog2(W + 1) + 1;

    logic [CW-1:0]  busy_cycles;
    logic [W-1:0]   cap_a, cap_b;
    logic           cap_sgn;
    logic [2*W-1:0] uprod;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cycles <= '0;
            cap_a       <= '0;
            cap_b       <= '0;
            cap_sgn     <= 1'b0;
        end else begin
            busy_cycles <= busy_o ? busy_cycles + 1'b1 : '0;
            if (start_i && !busy_o) begin
                cap_a   <= op_a_i;
                cap_b   <= op_b_i;
                cap_sgn <= signed_i;
            end
        end
    end

    always_comb uprod = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o));

    a_r2_unsigned_product: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cap_sgn) |-> ({res_hi_o, res_lo_o} == uprod));

    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_cycles == CW'(W)));

    a_r4_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({res_hi_o, res_lo_o}));

    a_r10_accept: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind shift_add_mul sam_checker #(.W(W)) u_sam_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .signed_i (signed_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .res_hi_o (res_hi_o),
    .res_lo_o (res_lo_o)
);

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] op_a_i = '0;
    logic [W-1:0] op_b_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] res_hi_o, res_lo_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    shift_add_mul #(.W(W)) dut (.*);

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] expect_prod(input logic [W-1:0] a, input logic [W-1:0] b,
                                                   input logic s);
        int ia, ib, p;
        ia = s ? int'($signed(a)) : int'(a);
        ib = s ? int'($signed(b)) : int'(b);
        p  = ia * ib;
        return p[2*W-1:0];
    endfunction

    // called at a negedge; returns at the negedge where done_o is seen
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input string req);
        int lat;
        op_a_i = a; op_b_i = b; signed_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        check("R5 done low after start", 64'(done_o), 64'd0);
        while (!done_o && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check("R4 latency", 64'(lat), 64'(W + 1));
        check(req, 64'({res_hi_o, res_lo_o}), 64'(expect_prod(a, b, s)));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 64'(busy_o), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 64'(busy_o), 64'd0);
        check("R1 done after reset", 64'(done_o), 64'd0);
        check("R1 result after reset", 64'({res_hi_o, res_lo_o}), 64'd0);

        // R3 all ones, first request from idle
        run_op('1, '1, 1'b0, "R3 carry kept");
        // R10: every following request is raised in the done cycle
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_op(W'(a), W'(b), 1'b0, "R2 unsigned");
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_op(W'(a), W'(b), 1'b1, "R7 signed");
        run_op({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b1, "R8 min*min");
        run_op({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, 1'b1, "R8 min*max");
        run_op('1, {1'b1, {(W-1){1'b0}}}, 1'b1, "R8 -1*min");

        // R9 hold
        held = {res_hi_o, res_lo_o};
        @(negedge clk);
        check("R5 single pulse", 64'(done_o), 64'd0);
        repeat (3) @(negedge clk);
        check("R9 hold", 64'({res_hi_o, res_lo_o}), 64'(held));

        // R6 start while busy is ignored
        op_a_i = 4'd3; op_b_i = 4'd5; signed_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        op_a_i = 4'd9; op_b_i = 4'd9; signed_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 busy kept", 64'(busy_o), 64'd1);
        repeat (W - 1) @(negedge clk);
        check("R6 done timing", 64'(done_o), 64'd1);
        check("R6 operands kept", 64'({res_hi_o, res_lo_o}), 64'd15);
        @(negedge clk);
        check("R6 no second op", 64'(busy_o), 64'd0);
        repeat (W + 2) @(negedge clk);
        check("R6 no late done", 64'(done_o), 64'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule